// File: doc/BRIEF.md
# Display Controller Control and Status Register File

This block holds the control and status byte registers of a display controller. It sits in the upper half of a 32-byte, byte-wide register window. A control byte carries the vertical-sync interrupt enable in its top bit. A status byte reports a live interrupt-pending flag together with fixed identification bits. The remaining fourteen bytes are plain storage that cursor and video-timing logic elsewhere can use. Offsets in the lower half of the window belong to other logic and read back as zero from here.

The timing generator pulses `vsync_pulse` for one cycle at the end of each frame. If interrupts are enabled, that pulse sets the pending flag. The flag drives the level interrupt `irq` until software writes anything to the status byte. Read data is registered and appears in the cycle after the read strobe.

Top module: `disp_ctl_regs`

## Requirements
- R1: Offset 0x10 is the control byte. It reads back the full value last written, and its bit 7 is the vertical-sync interrupt enable.
- R2: A read of offset 0x11 returns 0x61 when no interrupt is pending and 0xE1 when one is: bit 7 is the pending flag, and bits 6:5 = 11 and bit 0 = 1 are fixed identification bits.
- R3: Any write to offset 0x11 clears the pending flag, whatever the data value. `irq` is low in the following cycle and the status byte reads 0x61.
- R4: A `vsync_pulse` cycle in which control bit 7 is 1 sets the pending flag, and `irq` is high from the next cycle.
- R5: A `vsync_pulse` cycle in which control bit 7 is 0 leaves `irq` low and the status byte at 0x61.
- R6: Offsets 0x12 to 0x1F are fourteen independent read/write storage bytes. Each reads back its own last written value.
- R7: Offsets 0x00 to 0x0F read as zero, and writes to them change neither the control byte, the storage bytes nor `irq`.
- R8: When a status write and an enabled `vsync_pulse` fall in the same cycle, the pending flag ends up set and `irq` stays high.
- R9: After reset, `irq` is low, the control byte and all storage bytes read zero, and the status byte reads 0x61.
- R10: `rd_data` shows the addressed value in the cycle after `rd_en`. A write to the same offset in the same cycle is not yet visible in that read. In a cycle that follows no read, `rd_data` is zero.
- R11: `irq` is a level signal equal to the pending flag. It stays high through further sync pulses and unrelated writes until a status write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte offset within the register window, shared by reads and writes |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| vsync_pulse | input | 1 | One-cycle frame-end sync event from the timing generator |
| irq | output | 1 | Level interrupt, high while an interrupt is pending |

## Verification
The embedded properties assume that `vsync_pulse`, `wr_en` and `rd_en` are clean single-cycle strobes sampled at the rising edge. They also assume the address is stable in any cycle where a strobe is active. They treat a status write and an enabled sync in the same cycle as a legal collision that resolves to the flag being set. The stimulus drives every strobe and the address at the falling edge and holds each strobe for exactly one cycle. Same-cycle collisions come only from the dedicated combined-access tasks, so every cycle the properties inspect has a defined input pattern.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   // Which register group an offset selects
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_STORE = 2'd3
   } dcr_sel_e;

   // Fixed identification bits merged into every status read
   localparam logic [7:0] STAT_ID_BITS = 8'h61;

   // Bit position of the enable (control) and pending flag (status)
   localparam int unsigned IRQ_BIT = 7;

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
   import dcr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned CTRL_OFF = 16,
   parameter int unsigned N_STORE  = 14,
   parameter int unsigned SIDX_W   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output dcr_sel_e          sel,
   output logic [SIDX_W-1:0] store_idx
);

   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(CTRL_OFF + 1);
   localparam logic [ADDR_W-1:0] STORE_A = ADDR_W'(CTRL_OFF + 2);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(CTRL_OFF + 1 + N_STORE);

   always_comb begin
      if (addr == CTRL_A) begin
         sel = SEL_CTRL;
      end else if (addr == STAT_A) begin
         sel = SEL_STAT;
      end else if (addr >= STORE_A && addr <= LAST_A) begin
         sel = SEL_STORE;
      end else begin
         sel = SEL_NONE;
      end
   end

   assign store_idx = SIDX_W'(addr - STORE_A);

endmodule

// File: rtl/dcr_store.sv
module dcr_store #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_STORE = 14,
   parameter int unsigned SIDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SIDX_W-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] bytes_q [N_STORE];

   for (genvar i = 0; i < N_STORE; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bytes_q[i] <= '0;
         end else if (we && idx == SIDX_W'(i)) begin
            bytes_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_STORE; i++) begin
         if (idx == SIDX_W'(i)) begin
            rdata = bytes_q[i];
         end
      end
   end

endmodule

// File: rtl/dcr_irq.sv
module dcr_irq
   import dcr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic              vsync,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              pend_q
);

   logic sync_hit;

   assign sync_hit = vsync && ctrl_q[IRQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= wdata;
      end
   end

   // The sync event takes priority over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (sync_hit) begin
         pend_q <= 1'b1;
      end else if (ack) begin
         pend_q <= 1'b0;
      end
   end

   AST_SYNC_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && ctrl_q[IRQ_BIT]) |=> pend_q); // R4
   AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !vsync) |=> !pend_q); // R3
   AST_COLLIDE_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && vsync && ctrl_q[IRQ_BIT]) |=> pend_q); // R8
   AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !ctrl_q[IRQ_BIT]) |=> !pend_q); // R5
   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack) |=> pend_q); // R11

endmodule

// File: rtl/disp_ctl_regs.sv
module disp_ctl_regs
   import dcr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTRL_OFF = 16,
   parameter bit          REG_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              vsync_pulse,
   output logic              irq
);

   localparam int unsigned WIN_BYTES = 1 << ADDR_W;
   localparam int unsigned N_STORE   = WIN_BYTES - CTRL_OFF - 2;
   localparam int unsigned SIDX_W    = (N_STORE > 1) ? $clog2(N_STORE) : 1;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CTRL_OFF + 1);

   initial begin : p_param_chk
      assert (DATA_W >= 8) else $error("DATA_W must hold the 8 status bits");
      assert (CTRL_OFF + 3 <= WIN_BYTES) else $error("window too small for the register set");
      assert (CTRL_OFF > 0) else $error("CTRL_OFF must leave an unmapped lower range");
   end

   dcr_sel_e          sel;
   logic [SIDX_W-1:0] store_idx;
   logic [DATA_W-1:0] ctrl_q;
   logic              pend_q;
   logic [DATA_W-1:0] store_rdata;
   logic [DATA_W-1:0] stat_val;
   logic [DATA_W-1:0] rd_mux;

   dcr_decode #(
      .ADDR_W   (ADDR_W),
      .CTRL_OFF (CTRL_OFF),
      .N_STORE  (N_STORE),
      .SIDX_W   (SIDX_W)
   ) i_decode (
      .addr      (addr),
      .sel       (sel),
      .store_idx (store_idx)
   );

   dcr_irq #(
      .DATA_W (DATA_W)
   ) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (wr_en && sel == SEL_CTRL),
      .wdata   (wr_data),
      .ack     (wr_en && sel == SEL_STAT),
      .vsync   (vsync_pulse),
      .ctrl_q  (ctrl_q),
      .pend_q  (pend_q)
   );

   dcr_store #(
      .DATA_W  (DATA_W),
      .N_STORE (N_STORE),
      .SIDX_W  (SIDX_W)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && sel == SEL_STORE),
      .idx   (store_idx),
      .wdata (wr_data),
      .rdata (store_rdata)
   );

   always_comb begin
      stat_val          = '0;
      stat_val[7:0]     = STAT_ID_BITS;
      stat_val[IRQ_BIT] = pend_q;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:  rd_mux = ctrl_q;
         SEL_STAT:  rd_mux = stat_val;
         SEL_STORE: rd_mux = store_rdata;
         default:   rd_mux = '0;
      endcase
   end

   assign irq = pend_q;

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data <= '0;
         end else begin
            rd_data <= rd_en ? rd_mux : '0;
         end
      end

      AST_LOW_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr < CTRL_A) |=> rd_data == '0); // R7
      AST_STAT_FIXED_ID: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == STAT_A) |=> rd_data[6:0] == STAT_ID_BITS[6:0]); // R2
      AST_STAT_LIVE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == STAT_A) |=> rd_data[IRQ_BIT] == $past(irq)); // R2
      AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> rd_data == '0); // R10
   end else begin : g_rd_comb
      assign rd_data = rd_en ? rd_mux : '0;
   end

endmodule

// File: tb/test_disp_ctl_regs.sv
module test_disp_ctl_regs;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] addr;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       rd_en;
   logic [7:0] rd_data;
   logic       vsync_pulse;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       rd_issued = 1'b0;

   always #5 clk = ~clk;

   disp_ctl_regs i_disp_ctl_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_data     (rd_data),
      .vsync_pulse (vsync_pulse),
      .irq         (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Monitor: a read strobed at a rising edge shows up at the next falling edge after the following rising edge
   always @(posedge clk) rd_issued <= rd_en;

   always @(negedge clk) begin
      if (rd_issued && rst_n) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected read data", rd_data, 8'h00);
         end else begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   task automatic do_rd(input logic [4:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr  = a;
      rd_en = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      addr    = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rw(input logic [4:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input string req);
      @(negedge clk);
      addr    = a;
      wr_data = d;
      wr_en   = 1'b1;
      rd_en   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
   endtask

   task automatic do_sync(input bit with_ack);
      @(negedge clk);
      vsync_pulse = 1'b1;
      if (with_ack) begin
         addr    = 5'h11;
         wr_data = 8'h00;
         wr_en   = 1'b1;
      end
      @(negedge clk);
      vsync_pulse = 1'b0;
      wr_en       = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   initial begin : p_watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin : p_main
      rst_n       = 1'b0;
      addr        = '0;
      wr_en       = 1'b0;
      wr_data     = '0;
      rd_en       = 1'b0;
      vsync_pulse = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 irq in reset", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;

      // R9 reset state
      check("R9 irq after reset", {7'b0, irq}, 8'h00);
      do_rd(5'h10, 8'h00, "R9 control after reset");
      do_rd(5'h11, 8'h61, "R9 status after reset");
      do_rd(5'h12, 8'h00, "R9 first storage after reset");
      do_rd(5'h1F, 8'h00, "R9 last storage after reset");
      drain();
      check("R10 idle rd_data zero", rd_data, 8'h00);

      // R1 control read-back, R5 sync ignored while disabled
      do_wr(5'h10, 8'h5A);
      do_rd(5'h10, 8'h5A, "R1 control readback");
      do_sync(1'b0);
      check("R5 irq stays low when disabled", {7'b0, irq}, 8'h00);
      do_rd(5'h11, 8'h61, "R5 status unchanged when disabled");

      // R4 enabled sync sets pending; R2 status shows it
      do_wr(5'h10, 8'h80);
      do_rd(5'h10, 8'h80, "R1 enable bit readback");
      do_sync(1'b0);
      check("R4 irq after enabled sync", {7'b0, irq}, 8'h01);
      do_rd(5'h11, 8'hE1, "R2 status with pending");

      // R11 level holds through further syncs and unrelated writes
      do_sync(1'b0);
      check("R11 irq after second sync", {7'b0, irq}, 8'h01);
      do_wr(5'h12, 8'h33);
      do_wr(5'h10, 8'h80);
      check("R11 irq after unrelated writes", {7'b0, irq}, 8'h01);

      // R3 status write clears regardless of data
      do_wr(5'h11, 8'h00);
      check("R3 irq after ack with 00", {7'b0, irq}, 8'h00);
      do_rd(5'h11, 8'h61, "R3 status after ack");
      do_sync(1'b0);
      check("R4 irq re-raised", {7'b0, irq}, 8'h01);
      do_wr(5'h11, 8'hFF);
      check("R3 irq after ack with FF", {7'b0, irq}, 8'h00);

      // R8 collision: sync wins
      do_sync(1'b1);
      check("R8 irq after sync plus ack", {7'b0, irq}, 8'h01);
      do_rd(5'h11, 8'hE1, "R8 status after collision");
      do_wr(5'h11, 8'h80);
      check("R3 irq cleared after collision", {7'b0, irq}, 8'h00);

      // R6 storage bytes are independent
      for (int o = 18; o < 32; o++) do_wr(5'(o), 8'(o * 37 + 5));
      for (int o = 18; o < 32; o++) do_rd(5'(o), 8'(o * 37 + 5), "R6 storage readback");

      // R7 lower range reads zero, writes ignored
      for (int o = 0; o < 16; o++) do_wr(5'(o), 8'hFF);
      for (int o = 0; o < 16; o++) do_rd(5'(o), 8'h00, "R7 low offset reads zero");
      do_rd(5'h10, 8'h80, "R7 control untouched by low writes");
      do_rd(5'h12, 8'(18 * 37 + 5), "R7 first storage untouched");
      do_rd(5'h1F, 8'(31 * 37 + 5), "R7 last storage untouched");
      check("R7 irq untouched by low writes", {7'b0, irq}, 8'h00);

      // R10 read sees the value from before a same-cycle write
      do_rw(5'h13, 8'hC4, 8'(19 * 37 + 5), "R10 read before same-cycle write");
      do_rd(5'h13, 8'hC4, "R10 write visible on next read");
      do_rw(5'h10, 8'h01, 8'h80, "R10 control old value on same-cycle write");
      do_rd(5'h10, 8'h01, "R1 control new value");
      drain();
      check("R10 idle rd_data zero at end", rd_data, 8'h00);
      check("R10 scoreboard drained", 8'(exp_q.size()), 8'h00);

      finish_run();
   end

endmodule